// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins. Software controls it through 32-bit single-cycle register accesses. Each pin gets a function through a 2-bit mode field: digital input, digital output, alternate function or analog. Further per-pin fields choose the following:

- a push-pull or open-drain driver;
- a 2-bit speed grade;
- a pull resistor;
- a 4-bit alternate-function selector.

The block keeps an output data latch. That latch can be written whole, or changed pin by pin through an atomic set/clear register, which avoids read-modify-write races between software contexts. Pad levels pass through a two-stage synchronizer into a readable input register.

Toward the pad ring the block drives these per-pin signals:

- output enable;
- output value;
- open-drain flag;
- pull-up and pull-down requests;
- an alternate-mode flag;
- the speed grade;
- the alternate-function select code.

The alternate-function peripherals, the analog paths and configuration locking are outside this block.

Writes take effect at the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Byte address bits [1:0] are ignored.

Top module: `gpio_port16`

## Requirements
- R1: After reset every register reads zero. `pad_oe`, `pad_out`, `pad_pu`, `pad_pd`, `pad_alt_en`, `pad_speed` and `pad_af_sel` are all zero.
- R2: The mode register sits at offset 0x00. Pin n uses bits [2n+1:2n]: 0 input, 1 output, 2 alternate, 3 analog. `pad_alt_en[n]` is high only in mode 2, and `pad_oe[n]` can be high only in mode 1.
- R3: The driver-type register sits at 0x04, with bit n for pin n (1 = open-drain), mirrored on `pad_od[n]`. In output mode an open-drain pin asserts `pad_oe[n]` only while its output data bit is 0. A push-pull pin always asserts it.
- R4: The pull register sits at 0x0C, with 2 bits per pin at [2n+1:2n]. Value 1 raises `pad_pu[n]` and value 2 raises `pad_pd[n]`. Values 0 and 3 raise neither. The written value reads back unchanged.
- R5: The speed register sits at 0x08, with 2 bits per pin at [2n+1:2n]. It reads back and appears on `pad_speed`.
- R6: Each pin has a 4-bit alternate-function code at bit (n mod 8)*4. Pins 0 to 7 live in the word at 0x20 and pins 8 to 15 in the word at 0x24. `pad_af_sel` is {word 0x24, word 0x20}.
- R7: The output data register sits at 0x14. Bits [15:0] are writable, read back and drive `pad_out`.
- R8: The set/clear register sits at 0x18. Writing 1 to bit n sets output data bit n, and writing 1 to bit n+16 clears it. Zero bits leave the pin alone. When both bits for one pin are 1, set wins.
- R9: The input register at 0x10 returns `pad_in` in bits [15:0]. A change becomes visible after the second rising edge, not the first.
- R10: The following read as zero:
  - offsets 0x18 and 0x1C;
  - word offsets 0x28 to 0x3C;
  - bits [31:16] of 0x04, 0x10 and 0x14.

  Writes to 0x10, 0x1C and unused offsets change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 16 | Pad levels, asynchronous |
| pad_oe | output | 16 | Drive enable per pin |
| pad_out | output | 16 | Output level per pin |
| pad_od | output | 16 | Open-drain driver selected |
| pad_pu | output | 16 | Pull-up requested |
| pad_pd | output | 16 | Pull-down requested |
| pad_alt_en | output | 16 | Pin is in alternate-function mode |
| pad_speed | output | 32 | Speed grade, 2 bits per pin |
| pad_af_sel | output | 64 | Alternate-function code, 4 bits per pin |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` carry known values whenever `bus_wr` is high. They also assume that output-side registers change only through a write. The random stimulus always drives defined data, writes only on the falling edge and changes `pad_in` only while the bus is idle. It mixes legal register offsets with unused ones and values that set both halves of the set/clear word for the same pin.

// File: rtl/gpio_port16.sv
module gpio_port16 #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pad_in,
  output logic [15:0]       pad_oe,
  output logic [15:0]       pad_out,
  output logic [15:0]       pad_od,
  output logic [15:0]       pad_pu,
  output logic [15:0]       pad_pd,
  output logic [15:0]       pad_alt_en,
  output logic [31:0]       pad_speed,
  output logic [63:0]       pad_af_sel
);
  localparam int NPIN = 16;
  localparam int WW   = ADDR_W - 2;
  localparam logic [WW-1:0] W_MODE = WW'(0), W_TYPE = WW'(1), W_SPD = WW'(2),
    W_PULL = WW'(3), W_DIN = WW'(4), W_DOUT = WW'(5), W_SETCLR = WW'(6),
    W_AFLO = WW'(8), W_AFHI = WW'(9);

  logic [2*NPIN-1:0] mode_q, spd_q, pull_q;
  logic [NPIN-1:0]   type_q, dout_q, meta_q, din_q;
  logic [31:0]       aflo_q, afhi_q;
  logic [WW-1:0]     widx;

  assign widx = bus_addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; spd_q <= '0; pull_q <= '0;
      type_q <= '0; dout_q <= '0; meta_q <= '0; din_q <= '0;
      aflo_q <= '0; afhi_q <= '0;
    end else begin
      meta_q <= pad_in;
      din_q  <= meta_q;
      if (bus_wr) begin
        case (widx)
          W_MODE:   mode_q <= bus_wdata;
          W_TYPE:   type_q <= bus_wdata[NPIN-1:0];
          W_SPD:    spd_q  <= bus_wdata;
          W_PULL:   pull_q <= bus_wdata;
          W_DOUT:   dout_q <= bus_wdata[NPIN-1:0];
          W_SETCLR: dout_q <= (dout_q & ~bus_wdata[31:16]) | bus_wdata[15:0];
          W_AFLO:   aflo_q <= bus_wdata;
          W_AFHI:   afhi_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      W_MODE:  bus_rdata = mode_q;
      W_TYPE:  bus_rdata = {16'h0, type_q};
      W_SPD:   bus_rdata = spd_q;
      W_PULL:  bus_rdata = pull_q;
      W_DIN:   bus_rdata = {16'h0, din_q};
      W_DOUT:  bus_rdata = {16'h0, dout_q};
      W_AFLO:  bus_rdata = aflo_q;
      W_AFHI:  bus_rdata = afhi_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [1:0] md, pl;
    assign md            = mode_q[2*g +: 2];
    assign pl            = pull_q[2*g +: 2];
    assign pad_oe[g]     = (md == 2'd1) && (!type_q[g] || !dout_q[g]);
    assign pad_alt_en[g] = (md == 2'd2);
    assign pad_pu[g]     = (pl == 2'd1);
    assign pad_pd[g]     = (pl == 2'd2);
  end

  assign pad_out    = dout_q;
  assign pad_od     = type_q;
  assign pad_speed  = spd_q;
  assign pad_af_sel = {afhi_q, aflo_q};

  // R8
  setclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == W_SETCLR) |=>
      ((pad_out & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0])));

  // R8
  setclr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == W_SETCLR) |=>
      ((pad_out & $past(bus_wdata[31:16] & ~bus_wdata[15:0])) == 16'h0));

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_out));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_oe));

  // R10
  lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (widx == W_DIN || widx > W_AFHI || widx == WW'(7))) |=>
      ($stable(pad_out) && $stable(pad_af_sel) && $stable(pad_speed)));
endmodule

// File: tb/gpio_port16_tb.sv
`timescale 1ns/1ps
module gpio_port16_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] pad_in = 0, pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_alt_en;
  logic [31:0] pad_speed;
  logic [63:0] pad_af_sel;
  int checks = 0, fails = 0;
  logic [31:0] m_mode, m_spd, m_pull, m_lo, m_hi;
  logic [15:0] m_type, m_dout;

  always #5 clk = ~clk;

  gpio_port16 dut_i (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .pad_in, .pad_oe, .pad_out, .pad_od, .pad_pu, .pad_pd, .pad_alt_en,
    .pad_speed, .pad_af_sel);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int w);
    case (w)
      0: return m_mode;
      1: return {16'h0, m_type};
      2: return m_spd;
      3: return m_pull;
      4: return {16'h0, pad_in};
      5: return {16'h0, m_dout};
      8: return m_lo;
      9: return m_hi;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = (m_mode[2*i +: 2] == 2'd1) && (!m_type[i] || !m_dout[i]);
    return r;
  endfunction

  function automatic logic [47:0] exp_misc();
    logic [15:0] a, u, d;
    for (int i = 0; i < 16; i++) begin
      a[i] = m_mode[2*i +: 2] == 2'd2;
      u[i] = m_pull[2*i +: 2] == 2'd1;
      d[i] = m_pull[2*i +: 2] == 2'd2;
    end
    return {a, u, d};
  endfunction

  task automatic model_wr(logic [5:0] a, logic [31:0] d);
    case (a[5:2])
      0: m_mode = d;
      1: m_type = d[15:0];
      2: m_spd = d;
      3: m_pull = d;
      5: m_dout = d[15:0];
      6: m_dout = (m_dout & ~d[31:16]) | d[15:0];
      8: m_lo = d;
      9: m_hi = d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    model_wr(a, d);
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 oe"}, {48'h0, pad_oe}, {48'h0, exp_oe()});
    chk({tag, " R2/R4 alt/pull"}, {16'h0, pad_alt_en, pad_pu, pad_pd}, {16'h0, exp_misc()});
    chk({tag, " R3 od"}, {48'h0, pad_od}, {48'h0, m_type});
    chk({tag, " R5 speed"}, {32'h0, pad_speed}, {32'h0, m_spd});
    chk({tag, " R6 af"}, pad_af_sel, {m_hi, m_lo});
    chk({tag, " R7 out"}, {48'h0, pad_out}, {48'h0, m_dout});
    for (int w = 0; w < 16; w++) begin
      bus_addr = 6'(w * 4 + (w % 4));
      #0.25;
      chk($sformatf("%s R10 read word %0d", tag, w), {32'h0, bus_rdata}, {32'h0, exp_rd(w)});
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20250611);
    m_mode = 0; m_spd = 0; m_pull = 0; m_lo = 0; m_hi = 0; m_type = 0; m_dout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    wr(6'h14, 32'hFFFF_00F0);
    wr(6'h18, 32'h0013_0001);
    chk("R8 set wins/clear", {48'h0, pad_out}, {48'h0, 16'h00E1});
    wr(6'h00, 32'h0000_0055);
    wr(6'h04, 32'h0000_0003);
    chk("R3 open-drain oe", {48'h0, pad_oe}, {48'h0, 16'h000E});
    wr(6'h0C, 32'h0000_00E4);
    chk("R4 pull codes", {32'h0, pad_pu, pad_pd}, {32'h0, 16'h0002, 16'h0004});
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    check_all("R10 ignored writes");

    @(negedge clk); pad_in = 16'hA5C3; bus_addr = 6'h10;
    @(negedge clk); #1;
    chk("R9 not after one edge", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk); #1;
    chk("R9 after two edges", {32'h0, bus_rdata}, {48'h0, 16'hA5C3});

    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) begin
        @(negedge clk); pad_in = 16'($urandom);
        repeat (2) @(negedge clk);
      end else begin
        logic [5:0] a;
        logic [31:0] d;
        a = 6'($urandom_range(0, 15) * 4 + $urandom_range(0, 3));
        d = $urandom;
        if ($urandom_range(0, 3) == 0) a = 6'h18;
        if ($urandom_range(0, 7) == 0) d = {d[15:0], d[15:0]};
        wr(a, d);
      end
      if (n % 8 == 0) begin
        @(negedge clk);
        check_all("random");
      end else begin
        chk("R7/R8 random out", {48'h0, pad_out}, {48'h0, m_dout});
        chk("R2/R3 random oe", {48'h0, pad_oe}, {48'h0, exp_oe()});
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule